// File: doc/BRIEF.md
# Held Display Latch with Direct-Drive LCD Segments

This block sits behind a free-running 3½-digit measurement converter. Each time the converter signals a finished result, the block may capture the signed count. The count is a magnitude of 0 to 1999 with a sign flag and an overrange flag. The block turns the stored value into segment patterns for a static liquid-crystal display. That display has three full seven-segment digits, one shared output for the two segments of the leading "1", and a minus segment.

An active-high freeze control stops the capture while the converter keeps running, so the shown reading stays fixed for as long as the control is held. Tying the control low gives normal running operation.

Each segment line is driven against a common backplane square wave. A dark segment follows the backplane, and a lit segment is its inverse. The backplane is timed from the system clock and re-phased at every result strobe, so that forty half-periods fit into one nominal conversion.

Top module: `disp_hold_lcd`

## Requirements
- R1: After synchronous reset the display shows a zero reading: all three digits show the pattern for 0, the leading-1 output and the minus output are dark, and the backplane is low.
- R2: The stored reading is replaced only at a clock edge where `rdy` is high and `hold` is low. All segment outputs take the new value in the cycle after that edge, together.
- R3: While `hold` is high, strobes on `rdy` load nothing and the shown reading stays frozen however many strobes arrive. After `hold` falls, the next strobe loads again.
- R4: Without a strobe, the lit/dark state of every segment stays unchanged.
- R5: Every segment output equals `bp` XOR lit: a dark segment is in phase with the backplane and a lit one is inverted. In `seg_digit`, bits [6:0] are the units digit, [13:7] the tens and [20:14] the hundreds. Within a digit, bit 0 is segment a, continuing through bit 6 as segment g.
- R6: The backplane goes low at every strobe edge, whether or not `hold` is set. It then toggles every CONV_CYCLES/40 clock cycles, so after CONV_CYCLES cycles without a strobe it has made 40 half-periods and is low again.
- R7: A magnitude of 0 to 1999 is shown in decimal on the three digits using the usual seven-segment shapes (0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F). Leading zeros are shown. The leading-1 output is lit exactly when the magnitude is 1000 or more.
- R8: When the overrange flag is set, or when the magnitude is above 1999, the leading-1 output is lit, all three digits are dark, and the minus output still follows the sign flag.
- R9: The minus output is lit only when the sign flag is set and the reading is nonzero or overrange. A zero magnitude never shows a minus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rdy | input | 1 | One-cycle result-ready strobe from the converter |
| mag | input | 11 | Result magnitude, binary |
| neg | input | 1 | Result sign, 1 = negative |
| ovr | input | 1 | Result overrange flag |
| hold | input | 1 | Display freeze, active high; low = running |
| seg_digit | output | 21 | Segment lines of the three full digits |
| seg_half | output | 1 | Shared segment line of the leading "1" |
| seg_minus | output | 1 | Minus-sign segment line |
| bp | output | 1 | Backplane square wave |

## Verification
The decoder is tried with directed readings at the edges of the range (0, 9, 10, 99, 100, 999, 1000, 1999). These tell apart errors in digit order, carries between decimal places and the leading-1 threshold. The bench also drives negative zero, flagged overrange and an out-of-range magnitude without the flag, which tells the sign rule apart from the blanking rule. Random readings are then mixed with random freeze levels and gaps, so that loads made under freeze are separated from genuine loads. The backplane is followed cycle by cycle over a whole conversion to tell its half-period and re-phasing apart.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int MAG_W = 11;
    localparam int NDIG  = 3;
    localparam int SEG_W = 7;
    localparam int BCD_W = 4 * (NDIG + 1);
    localparam int MAX_SHOWN = 1999;

    typedef struct packed {
        logic             neg;
        logic             ovr;
        logic [MAG_W-1:0] mag;
    } reading_t;

    typedef struct packed {
        logic                    minus;
        logic                    half;
        logic [NDIG*SEG_W-1:0]   digits;
    } lit_t;

    function automatic logic [BCD_W-1:0] bin2bcd(input logic [MAG_W-1:0] b);
        logic [BCD_W-1:0] r;
        r = '0;
        for (int i = MAG_W - 1; i >= 0; i--) begin
            for (int d = 0; d < NDIG + 1; d++) begin
                if (r[4*d +: 4] >= 4'd5) r[4*d +: 4] = r[4*d +: 4] + 4'd3;
            end
            r = {r[BCD_W-2:0], b[i]};
        end
        return r;
    endfunction

    function automatic logic [SEG_W-1:0] seg7(input logic [3:0] v);
        logic [SEG_W-1:0] s;
        case (v)
            4'd0: s = 7'h3F;
            4'd1: s = 7'h06;
            4'd2: s = 7'h5B;
            4'd3: s = 7'h4F;
            4'd4: s = 7'h66;
            4'd5: s = 7'h6D;
            4'd6: s = 7'h7D;
            4'd7: s = 7'h07;
            4'd8: s = 7'h7F;
            4'd9: s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/disp_latch.sv
module disp_latch
    import disp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rdy,
    input  logic     hold,
    input  reading_t rd_in,
    output reading_t rd_q
);
    logic load;
    assign load = rdy & ~hold;

    always_ff @(posedge clk) begin
        if (rst)       rd_q <= '0;
        else if (load) rd_q <= rd_in;
    end
endmodule

// File: rtl/disp_encode.sv
module disp_encode
    import disp_pkg::*;
(
    input  reading_t rd,
    output lit_t     lit
);
    logic [BCD_W-1:0] bcd;
    logic             over;
    logic             nonzero;

    assign bcd     = bin2bcd(rd.mag);
    assign over    = rd.ovr | (rd.mag > MAG_W'(MAX_SHOWN));
    assign nonzero = |rd.mag;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign lit.digits[g*SEG_W +: SEG_W] = over ? '0 : seg7(bcd[4*g +: 4]);
    end

    assign lit.half  = over | (bcd[4*NDIG +: 4] != 4'd0);
    assign lit.minus = rd.neg & (over | nonzero);
endmodule

// File: rtl/disp_backplane.sv
module disp_backplane #(
    parameter int HALF = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic sync,
    output logic bp
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || sync) begin
            cnt <= '0;
            bp  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            bp  <= ~bp;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/disp_hold_lcd.sv
module disp_hold_lcd
    import disp_pkg::*;
#(
    parameter int CONV_CYCLES  = 400,
    parameter int HALF_PERIODS = 40
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rdy,
    input  logic [MAG_W-1:0]      mag,
    input  logic                  neg,
    input  logic                  ovr,
    input  logic                  hold,
    output logic [NDIG*SEG_W-1:0] seg_digit,
    output logic                  seg_half,
    output logic                  seg_minus,
    output logic                  bp
);
    localparam int HALF = CONV_CYCLES / HALF_PERIODS;

    reading_t rd_in, rd_q;
    lit_t     lit;

    assign rd_in = '{neg: neg, ovr: ovr, mag: mag};

    disp_latch u_latch (
        .clk(clk), .rst(rst), .rdy(rdy), .hold(hold),
        .rd_in(rd_in), .rd_q(rd_q)
    );

    disp_encode u_enc (.rd(rd_q), .lit(lit));

    disp_backplane #(.HALF(HALF)) u_bp (
        .clk(clk), .rst(rst), .sync(rdy), .bp(bp)
    );

    assign seg_digit = lit.digits ^ {(NDIG*SEG_W){bp}};
    assign seg_half  = lit.half ^ bp;
    assign seg_minus = lit.minus ^ bp;
endmodule

// File: rtl/disp_hold_lcd_chk.sv
module disp_hold_lcd_chk
    import disp_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  rdy,
    input logic                  hold,
    input logic                  neg,
    input logic                  ovr,
    input logic [NDIG*SEG_W-1:0] seg_digit,
    input logic                  seg_half,
    input logic                  seg_minus,
    input logic                  bp
);
    localparam int DW = NDIG * SEG_W;
    logic [DW+1:0] shown;
    assign shown = {seg_minus, seg_half, seg_digit} ^ {(DW+2){bp}};

    p_hold_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        (rdy && hold) |=> $stable(shown));

    p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> $stable(shown));

    p_bp_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        rdy |=> !bp);

    p_ovr_blank_r8: assert property (@(posedge clk) disable iff (rst)
        (rdy && !hold && ovr) |=> (seg_half != bp) && (seg_digit == {DW{bp}}));

    p_minus_off_r9: assert property (@(posedge clk) disable iff (rst)
        (rdy && !hold && !neg) |=> (seg_minus == bp));
endmodule

bind disp_hold_lcd disp_hold_lcd_chk u_chk (.*);

// File: tb/disp_hold_lcd_bench.sv
module disp_hold_lcd_bench;
    localparam int CONV = 400;
    localparam int HALF = CONV / 40;
    localparam int SW   = 23;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rdy = 1'b0;
    logic [10:0] mag = '0;
    logic        neg = 1'b0;
    logic        ovr = 1'b0;
    logic        hold = 1'b0;
    logic [20:0] seg_digit;
    logic        seg_half, seg_minus, bp;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int cur_m = 0;
    bit cur_n = 0, cur_o = 0;

    always #10 clk = ~clk;

    disp_hold_lcd #(.CONV_CYCLES(CONV)) u_disp_hold_lcd (
        .clk(clk), .rst(rst), .rdy(rdy), .mag(mag), .neg(neg), .ovr(ovr),
        .hold(hold), .seg_digit(seg_digit), .seg_half(seg_half),
        .seg_minus(seg_minus), .bp(bp)
    );

    function automatic logic [6:0] shape(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    function automatic logic [SW-1:0] expect_lit(input int m, input bit n, input bit o);
        bit over;
        logic [SW-1:0] e;
        over = o || (m > 1999);
        if (over) e = {1'b0, 1'b1, 21'b0};
        else e = {1'b0, (m >= 1000), shape((m / 100) % 10), shape((m / 10) % 10), shape(m % 10)};
        e[SW-1] = n && (over || m != 0);
        return e;
    endfunction

    task automatic check_disp(input string req);
        logic [SW-1:0] act, exp;
        act = {seg_minus, seg_half, seg_digit} ^ {SW{bp}};
        exp = expect_lit(cur_m, cur_n, cur_o);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lit pattern %h, expected %h (m=%0d n=%0d o=%0d)",
                     req, act, exp, cur_m, cur_n, cur_o);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b, expected %b", req, act, exp);
        end
    endtask

    // strobe a result; returns at the negedge after the capturing edge
    task automatic strobe(input int m, input bit n, input bit o, input bit h);
        @(negedge clk);
        mag = 11'(m); neg = n; ovr = o; hold = h; rdy = 1'b1;
        @(negedge clk);
        rdy = 1'b0;
        if (!h) begin cur_m = m; cur_n = n; cur_o = o; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout, expected completion");
        finish_run();
    end

    initial begin
        int dir [8] = '{0, 9, 10, 99, 100, 999, 1000, 1999};
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_disp("R1 reset zero reading");
        check_bit("R1 reset backplane", bp, 1'b0);

        foreach (dir[i]) begin
            strobe(dir[i], 1'b0, 1'b0, 1'b0);
            check_disp("R7 R2 directed decode");
            check_bit("R6 backplane low after strobe", bp, 1'b0);
        end

        strobe(0, 1'b1, 1'b0, 1'b0);
        check_disp("R9 negative zero shows no minus");
        strobe(1234, 1'b1, 1'b0, 1'b0);
        check_disp("R9 minus on negative reading");
        strobe(517, 1'b1, 1'b1, 1'b0);
        check_disp("R8 flagged overrange keeps sign");
        strobe(2047, 1'b0, 1'b0, 1'b0);
        check_disp("R8 magnitude above 1999 blanks");

        // freeze: value must not change under several strobes
        strobe(321, 1'b0, 1'b0, 1'b0);
        strobe(888, 1'b1, 1'b0, 1'b1);
        check_disp("R3 strobe under hold ignored");
        check_bit("R6 strobe under hold re-phases backplane", bp, 1'b0);
        strobe(1555, 1'b0, 1'b1, 1'b1);
        check_disp("R3 second strobe under hold ignored");
        @(negedge clk); hold = 1'b0;
        repeat (5) @(negedge clk);
        check_disp("R3 hold release alone loads nothing");
        strobe(76, 1'b1, 1'b0, 1'b0);
        check_disp("R3 load resumes after release");

        // backplane over one whole conversion; display stays put (R4, R5)
        begin
            int bad = 0;
            for (int k = 1; k <= CONV; k++) begin
                @(negedge clk);
                if (bp !== 1'(((k / HALF) % 2))) bad++;
                if (({seg_minus, seg_half, seg_digit} ^ {SW{bp}}) !== expect_lit(cur_m, cur_n, cur_o)) bad++;
            end
            checks++;
            if (bad != 0) begin
                errors++;
                $display("FAIL R6 R5 R4 backplane/phase over conversion: %0d bad cycles, expected 0", bad);
            end
            check_bit("R6 backplane low after 40 half-periods", bp, 1'b0);
        end

        // random mix
        for (int it = 0; it < 300; it++) begin
            int m; bit n, o, h;
            m = int'($urandom_range(0, 1999));
            n = 1'($urandom_range(0, 1));
            o = ($urandom_range(0, 7) == 0);
            h = ($urandom_range(0, 3) == 0);
            strobe(m, n, o, h);
            check_disp(h ? "R3 random hold" : "R2 R7 random load");
            repeat ($urandom_range(0, 30)) @(negedge clk);
            check_disp("R4 R5 random idle");
            hold = 1'b0;
        end

        finish_run();
    end
endmodule